// File: doc/BRIEF.md
# Vectored Interrupt Entry Sequencer

This block carries out interrupt entry for a 16-bit processor that forms 20-bit physical addresses from a segment and an offset. At each instruction boundary it chooses one of three sources. The first is a software trigger from the instruction that just finished: a numbered INT, a one-byte breakpoint, or a trap that fires only on overflow. The second is a non-maskable request line, which is latched on its rising edge. The third is a maskable request line, gated by the interrupt-enable flag. The chosen source gives an 8-bit type number. For a maskable request, the block first runs two acknowledge cycles and reads the type from the data bus.

The block then drives a single-cycle, word-wide memory bus. It pushes the flags word, the return segment and the return offset onto the stack. It reads the new offset and the new segment from the vector table in the lowest kilobyte of memory. It then presents the new segment, the new offset, a flags word with interrupt-enable and trap cleared, and the final stack pointer, together with a one-cycle completion pulse. The core applies these values.

The controller has nine states:
- `ST_IDLE`: waits for a boundary.
- `ST_ACK1` and `ST_ACK2`: the acknowledge pair.
- `ST_PUSH_FL`, `ST_PUSH_CS` and `ST_PUSH_IP`: the three stack writes.
- `ST_RD_IP` and `ST_RD_CS`: the two vector reads.
- `ST_DONE`: the completion pulse.

Its transitions are:
- `ST_IDLE` → `ST_PUSH_FL` for a software or non-maskable entry.
- `ST_IDLE` → `ST_ACK1` for a maskable entry.
- `ST_IDLE` → `ST_DONE` when an overflow trap is not taken.
- `ST_ACK1` → `ST_ACK2` → `ST_PUSH_FL`.
- `ST_PUSH_FL` → `ST_PUSH_CS` → `ST_PUSH_IP` → `ST_RD_IP` → `ST_RD_CS` → `ST_DONE` → `ST_IDLE`.

Top module: `irq_entry_seq`

## Requirements
- R1: The new offset is read from physical address type×4 and then the new segment from type×4+2, in consecutive cycles right after the last push. Both reads fall in the lowest 1 KB.
- R2: Three writes happen in consecutive cycles: the flags word at SS:(SP−2), the return segment at SS:(SP−4), then the return offset at SS:(SP−6). The physical address is SS×16+offset, truncated to 20 bits, and the offset wraps at 16 bits. After entry, `sp_o` equals SP−6.
- R3: The pushed flags word is the unmodified `flags_i`. `new_flags_o` is that word with interrupt-enable (bit 9) and trap (bit 8) cleared.
- R4: A rising edge on `nmi_i` makes a non-maskable request of type 2 that is served whatever the value of bit 9. Holding the line high does not request again.
- R5: When several sources are present at one boundary, a software trigger wins over a non-maskable request, which wins over a maskable request. The losing requests stay pending for later boundaries.
- R6: `intr_i` is sampled only in a boundary cycle and only when flags bit 9 is 1. A level that is gone by the next boundary is never served.
- R7: A maskable entry drives `inta_o` for exactly two consecutive cycles with no bus request. The type is taken from `mem_rdata_i[7:0]` in the second cycle.
- R8: `sw_kind_i` encodes the software trigger: 00 none, 01 numbered INT with its type on `sw_type_i`, 10 breakpoint (type 3), 11 overflow trap (type 4, taken only when flags bit 11 is 1).
- R9: An overflow trap with bit 11 clear is not a software trigger. If no hardware source is present, the block gives a completion pulse with `taken_o` low and no bus cycle. Otherwise the hardware source is served.
- R10: A boundary that arrives while an entry is in progress is ignored. A non-maskable edge that arrives during an entry is held and served at the first boundary after completion.
- R11: `done_o` rises for one cycle, in the cycle after the segment read. In that cycle `vec_type_o`, `new_cs_o`, `new_ip_o`, `new_flags_o` and `sp_o` are valid, and they hold their values afterwards.
- R12: After reset the block is idle: no bus request, no acknowledge, no completion pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| boundary_i | input | 1 | Instruction boundary strobe |
| sw_kind_i | input | 2 | Software trigger kind of the finishing instruction |
| sw_type_i | input | 8 | Type byte of a numbered INT |
| nmi_i | input | 1 | Non-maskable request, edge sensitive |
| intr_i | input | 1 | Maskable request, level sensitive |
| flags_i | input | 16 | Current flags word |
| cs_i | input | 16 | Return segment |
| ip_i | input | 16 | Return offset (next instruction) |
| ss_i | input | 16 | Stack segment |
| sp_i | input | 16 | Stack pointer |
| mem_req_o | output | 1 | Bus cycle this clock |
| mem_we_o | output | 1 | Bus cycle is a write |
| mem_addr_o | output | 20 | Physical byte address |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, sampled at the end of the cycle |
| inta_o | output | 1 | Interrupt acknowledge |
| done_o | output | 1 | Entry complete pulse |
| taken_o | output | 1 | Entry actually performed |
| vec_type_o | output | 8 | Served type number |
| new_cs_o | output | 16 | Handler segment |
| new_ip_o | output | 16 | Handler offset |
| new_flags_o | output | 16 | Flags with enable and trap cleared |
| sp_o | output | 16 | Stack pointer after the pushes |

## Verification
Two things can land in the same cycle: arbitration at a boundary, and the capture of a non-maskable edge. The bench raises `nmi_i` in the very cycle of a boundary that also carries a software trigger and an active maskable line. The software entry must run first, and the non-maskable and maskable entries must follow at the next two boundaries. The bench also raises the edge, and offers a new boundary, while an entry is still driving the bus. The stray boundary must leave the bus untouched, and the held edge must be served at the first boundary after completion. A behavioural model predicts the expected value of every port on every cycle.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    typedef enum logic [1:0] {
        SW_NONE = 2'b00,
        SW_INTN = 2'b01,
        SW_BRK  = 2'b10,
        SW_INTO = 2'b11
    } sw_kind_e;

    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_SW,
        SRC_NMI,
        SRC_INTR,
        SRC_SKIP
    } src_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ACK1,
        ST_ACK2,
        ST_PUSH_FL,
        ST_PUSH_CS,
        ST_PUSH_IP,
        ST_RD_IP,
        ST_RD_CS,
        ST_DONE
    } state_e;

    localparam int TYPE_NMI_C = 2;
    localparam int TYPE_BRK_C = 3;
    localparam int TYPE_OVF_C = 4;

endpackage

// File: rtl/irq_nmi_latch.sv
module irq_nmi_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_i,
    input  logic consume_i,
    output logic pending_o
);
    logic nmi_q;
    logic pend_q;
    logic rise;

    assign rise      = nmi_i & ~nmi_q;
    assign pending_o = pend_q | rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nmi_q  <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            nmi_q  <= nmi_i;
            pend_q <= consume_i ? 1'b0 : (pend_q | rise);
        end
    end

    // R10: a held edge survives until the arbiter takes it
    p_nmi_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_o && !consume_i) |=> pending_o);

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_entry_pkg::*;
#(
    parameter int TYPE_W = 8
) (
    input  logic              boundary_i,
    input  logic              idle_i,
    input  sw_kind_e          sw_kind_i,
    input  logic [TYPE_W-1:0] sw_type_i,
    input  logic              ovf_i,
    input  logic              ie_i,
    input  logic              nmi_pend_i,
    input  logic              intr_i,
    output src_e              src_o,
    output logic [TYPE_W-1:0] type_o,
    output logic              nmi_take_o
);
    always_comb begin
        src_o  = SRC_NONE;
        type_o = '0;
        if (boundary_i && idle_i) begin
            unique case (sw_kind_i)
                SW_INTN: begin
                    src_o  = SRC_SW;
                    type_o = sw_type_i;
                end
                SW_BRK: begin
                    src_o  = SRC_SW;
                    type_o = TYPE_W'(TYPE_BRK_C);
                end
                SW_INTO: begin
                    if (ovf_i) begin
                        src_o  = SRC_SW;
                        type_o = TYPE_W'(TYPE_OVF_C);
                    end
                end
                default: ;
            endcase
            if (src_o == SRC_NONE) begin
                if (nmi_pend_i) begin
                    src_o  = SRC_NMI;
                    type_o = TYPE_W'(TYPE_NMI_C);
                end else if (intr_i && ie_i) begin
                    src_o = SRC_INTR;
                end else if (sw_kind_i == SW_INTO) begin
                    src_o = SRC_SKIP;
                end
            end
        end
    end

    assign nmi_take_o = (src_o == SRC_NMI);

endmodule

// File: rtl/irq_bus_seq.sv
module irq_bus_seq
    import irq_entry_pkg::*;
#(
    parameter int WORD_W    = 16,
    parameter int SEG_SHIFT = 4,
    parameter int PADDR_W   = 20,
    parameter int TYPE_W    = 8,
    parameter int IF_BIT    = 9,
    parameter int TF_BIT    = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  src_e               src_i,
    input  logic [TYPE_W-1:0]  type_i,
    input  logic [WORD_W-1:0]  flags_i,
    input  logic [WORD_W-1:0]  cs_i,
    input  logic [WORD_W-1:0]  ip_i,
    input  logic [WORD_W-1:0]  ss_i,
    input  logic [WORD_W-1:0]  sp_i,
    input  logic [WORD_W-1:0]  mem_rdata_i,
    output logic               idle_o,
    output logic               mem_req_o,
    output logic               mem_we_o,
    output logic [PADDR_W-1:0] mem_addr_o,
    output logic [WORD_W-1:0]  mem_wdata_o,
    output logic               inta_o,
    output logic               done_o,
    output logic               taken_o,
    output logic [TYPE_W-1:0]  vec_type_o,
    output logic [WORD_W-1:0]  new_cs_o,
    output logic [WORD_W-1:0]  new_ip_o,
    output logic [WORD_W-1:0]  new_flags_o,
    output logic [WORD_W-1:0]  sp_o
);
    localparam int WORD_BYTES = WORD_W / 8;
    localparam int VEC_SH     = $clog2(2 * WORD_BYTES);

    state_e              state_q, state_d;
    logic [TYPE_W-1:0]   typ_q;
    logic [WORD_W-1:0]   fl_q, cs_q, ip_q, ss_q, sp_q, ncs_q, nip_q;
    logic                taken_q;
    logic [PADDR_W-1:0]  stack_addr, vec_lo, vec_hi;

    assign stack_addr = PADDR_W'({ss_q, {SEG_SHIFT{1'b0}}}) + PADDR_W'(sp_q);
    assign vec_lo     = PADDR_W'({typ_q, {VEC_SH{1'b0}}});
    assign vec_hi     = vec_lo + PADDR_W'(WORD_BYTES);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                unique case (src_i)
                    SRC_SW, SRC_NMI: state_d = ST_PUSH_FL;
                    SRC_INTR:        state_d = ST_ACK1;
                    SRC_SKIP:        state_d = ST_DONE;
                    default:         state_d = ST_IDLE;
                endcase
            end
            ST_ACK1:    state_d = ST_ACK2;
            ST_ACK2:    state_d = ST_PUSH_FL;
            ST_PUSH_FL: state_d = ST_PUSH_CS;
            ST_PUSH_CS: state_d = ST_PUSH_IP;
            ST_PUSH_IP: state_d = ST_RD_IP;
            ST_RD_IP:   state_d = ST_RD_CS;
            ST_RD_CS:   state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // captured context and results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            typ_q   <= '0;
            fl_q    <= '0;
            cs_q    <= '0;
            ip_q    <= '0;
            ss_q    <= '0;
            sp_q    <= '0;
            ncs_q   <= '0;
            nip_q   <= '0;
            taken_q <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (src_i != SRC_NONE) begin
                        typ_q   <= type_i;
                        fl_q    <= flags_i;
                        cs_q    <= cs_i;
                        ip_q    <= ip_i;
                        ss_q    <= ss_i;
                        sp_q    <= sp_i - WORD_W'(WORD_BYTES);
                        taken_q <= (src_i != SRC_SKIP);
                    end
                end
                ST_ACK2:    typ_q <= mem_rdata_i[TYPE_W-1:0];
                ST_PUSH_FL,
                ST_PUSH_CS: sp_q  <= sp_q - WORD_W'(WORD_BYTES);
                ST_RD_IP:   nip_q <= mem_rdata_i;
                ST_RD_CS:   ncs_q <= mem_rdata_i;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = '0;
        inta_o      = 1'b0;
        done_o      = 1'b0;
        unique case (state_q)
            ST_ACK1, ST_ACK2: inta_o = 1'b1;
            ST_PUSH_FL: begin
                mem_req_o = 1'b1; mem_we_o = 1'b1;
                mem_addr_o = stack_addr; mem_wdata_o = fl_q;
            end
            ST_PUSH_CS: begin
                mem_req_o = 1'b1; mem_we_o = 1'b1;
                mem_addr_o = stack_addr; mem_wdata_o = cs_q;
            end
            ST_PUSH_IP: begin
                mem_req_o = 1'b1; mem_we_o = 1'b1;
                mem_addr_o = stack_addr; mem_wdata_o = ip_q;
            end
            ST_RD_IP: begin
                mem_req_o = 1'b1; mem_addr_o = vec_lo;
            end
            ST_RD_CS: begin
                mem_req_o = 1'b1; mem_addr_o = vec_hi;
            end
            ST_DONE: done_o = 1'b1;
            default: ;
        endcase
        new_flags_o         = fl_q;
        new_flags_o[IF_BIT] = 1'b0;
        new_flags_o[TF_BIT] = 1'b0;
    end

    assign idle_o     = (state_q == ST_IDLE);
    assign taken_o    = taken_q;
    assign vec_type_o = typ_q;
    assign new_cs_o   = ncs_q;
    assign new_ip_o   = nip_q;
    assign sp_o       = sp_q;

    p_ack_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(inta_o) |=> inta_o);
    p_ack_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (inta_o && $past(inta_o)) |=> !inta_o);
    p_ack_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        inta_o |-> !mem_req_o);
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_vec_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_we_o) |-> (mem_addr_o[PADDR_W-1:TYPE_W+VEC_SH] == '0));
    p_done_after_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && taken_o) |-> ($past(mem_req_o) && !$past(mem_we_o)));

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter int WORD_W    = 16,
    parameter int SEG_SHIFT = 4,
    parameter int PADDR_W   = 20,
    parameter int TYPE_W    = 8,
    parameter int IF_BIT    = 9,
    parameter int TF_BIT    = 8,
    parameter int OF_BIT    = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               boundary_i,
    input  logic [1:0]         sw_kind_i,
    input  logic [TYPE_W-1:0]  sw_type_i,
    input  logic               nmi_i,
    input  logic               intr_i,
    input  logic [WORD_W-1:0]  flags_i,
    input  logic [WORD_W-1:0]  cs_i,
    input  logic [WORD_W-1:0]  ip_i,
    input  logic [WORD_W-1:0]  ss_i,
    input  logic [WORD_W-1:0]  sp_i,
    output logic               mem_req_o,
    output logic               mem_we_o,
    output logic [PADDR_W-1:0] mem_addr_o,
    output logic [WORD_W-1:0]  mem_wdata_o,
    input  logic [WORD_W-1:0]  mem_rdata_i,
    output logic               inta_o,
    output logic               done_o,
    output logic               taken_o,
    output logic [TYPE_W-1:0]  vec_type_o,
    output logic [WORD_W-1:0]  new_cs_o,
    output logic [WORD_W-1:0]  new_ip_o,
    output logic [WORD_W-1:0]  new_flags_o,
    output logic [WORD_W-1:0]  sp_o
);
    logic              nmi_pend, nmi_take, idle;
    src_e              arb_src;
    logic [TYPE_W-1:0] arb_type;

    irq_nmi_latch u_nmi (
        .clk       (clk),
        .rst_n     (rst_n),
        .nmi_i     (nmi_i),
        .consume_i (nmi_take),
        .pending_o (nmi_pend)
    );

    irq_arbiter #(.TYPE_W(TYPE_W)) u_arb (
        .boundary_i (boundary_i),
        .idle_i     (idle),
        .sw_kind_i  (sw_kind_e'(sw_kind_i)),
        .sw_type_i  (sw_type_i),
        .ovf_i      (flags_i[OF_BIT]),
        .ie_i       (flags_i[IF_BIT]),
        .nmi_pend_i (nmi_pend),
        .intr_i     (intr_i),
        .src_o      (arb_src),
        .type_o     (arb_type),
        .nmi_take_o (nmi_take)
    );

    irq_bus_seq #(
        .WORD_W(WORD_W), .SEG_SHIFT(SEG_SHIFT), .PADDR_W(PADDR_W),
        .TYPE_W(TYPE_W), .IF_BIT(IF_BIT), .TF_BIT(TF_BIT)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_i       (arb_src),
        .type_i      (arb_type),
        .flags_i     (flags_i),
        .cs_i        (cs_i),
        .ip_i        (ip_i),
        .ss_i        (ss_i),
        .sp_i        (sp_i),
        .mem_rdata_i (mem_rdata_i),
        .idle_o      (idle),
        .mem_req_o   (mem_req_o),
        .mem_we_o    (mem_we_o),
        .mem_addr_o  (mem_addr_o),
        .mem_wdata_o (mem_wdata_o),
        .inta_o      (inta_o),
        .done_o      (done_o),
        .taken_o     (taken_o),
        .vec_type_o  (vec_type_o),
        .new_cs_o    (new_cs_o),
        .new_ip_o    (new_ip_o),
        .new_flags_o (new_flags_o),
        .sp_o        (sp_o)
    );

    p_nmi_over_intr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_src == SRC_INTR) |-> !nmi_pend);
    p_intr_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_src == SRC_INTR) |-> flags_i[IF_BIT]);
    p_busy_ignores_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |-> (arb_src == SRC_NONE));

endmodule

// File: tb/irq_entry_seq_tb.sv
module irq_entry_seq_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        boundary;
    logic [1:0]  sw_kind;
    logic [7:0]  sw_type;
    logic        nmi, intr;
    logic [15:0] flags, cs_v, ip_v, ss_v, sp_v;
    logic        mem_req, mem_we, inta, done, taken;
    logic [19:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata, new_cs, new_ip, new_flags, sp_out;
    logic [7:0]  vec_type;
    logic [7:0]  ack_type;

    int nvec = 0;
    int nbad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_entry_seq u_dut (
        .clk(clk), .rst_n(rst_n), .boundary_i(boundary), .sw_kind_i(sw_kind),
        .sw_type_i(sw_type), .nmi_i(nmi), .intr_i(intr), .flags_i(flags),
        .cs_i(cs_v), .ip_i(ip_v), .ss_i(ss_v), .sp_i(sp_v),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .inta_o(inta),
        .done_o(done), .taken_o(taken), .vec_type_o(vec_type),
        .new_cs_o(new_cs), .new_ip_o(new_ip), .new_flags_o(new_flags), .sp_o(sp_out)
    );

    function automatic logic [15:0] vw(input logic [19:0] a);
        logic [15:0] v;
        v = a[15:0] * 16'd37 + 16'h1234;
        return v;
    endfunction

    function automatic logic [19:0] ph(input logic [15:0] s, input logic [15:0] o);
        int v;
        v = int'(s) * 16 + int'(o);
        return v[19:0];
    endfunction

    // memory and acknowledge responder
    always_comb begin
        if (inta)                  mem_rdata = {8'h00, ack_type};
        else if (mem_req && !mem_we) mem_rdata = vw(mem_addr);
        else                       mem_rdata = 16'h0000;
    end

    typedef struct {
        bit req; bit we; bit inta; bit done; bit taken;
        logic [19:0] addr;
        logic [15:0] wd, ncs, nip, nfl, sp;
        logic [7:0]  typ;
        string       rq;
    } exp_t;

    exp_t  q[$];
    string idle_tag = "R12";
    bit    m_nmi_pend = 0;
    bit    nmi_lv = 0;

    function automatic exp_t blank(input string rq);
        exp_t e;
        e.req = 0; e.we = 0; e.inta = 0; e.done = 0; e.taken = 0;
        e.addr = '0; e.wd = '0; e.ncs = '0; e.nip = '0; e.nfl = '0; e.sp = '0;
        e.typ = '0; e.rq = rq;
        return e;
    endfunction

    task automatic chk(input string rq, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s %s: actual %h expected %h at %0t", rq, what, act, exp, $time);
        end
    endtask

    task automatic compare_one();
        exp_t e;
        if (q.size() > 0) e = q.pop_front();
        else              e = blank(idle_tag);
        chk(e.rq, "done", 32'(done), 32'(e.done));
        chk(e.rq, "mem_req", 32'(mem_req), 32'(e.req));
        chk(e.rq, "inta", 32'(inta), 32'(e.inta));
        if (e.req) begin
            chk(e.rq, "mem_we", 32'(mem_we), 32'(e.we));
            chk(e.rq, "mem_addr", 32'(mem_addr), 32'(e.addr));
            if (e.we) chk(e.rq, "mem_wdata", 32'(mem_wdata), 32'(e.wd));
        end
        if (e.done) begin
            chk(e.rq, "taken", 32'(taken), 32'(e.taken));
            if (e.taken) begin
                chk(e.rq, "vec_type", 32'(vec_type), 32'(e.typ));
                chk(e.rq, "new_cs", 32'(new_cs), 32'(e.ncs));
                chk(e.rq, "new_ip", 32'(new_ip), 32'(e.nip));
                chk(e.rq, "new_flags(R3)", 32'(new_flags), 32'(e.nfl));
                chk(e.rq, "sp_o", 32'(sp_out), 32'(e.sp));
            end
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        compare_one();
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic set_nmi(input logic v);
        if (v && !nmi_lv) m_nmi_pend = 1;
        nmi_lv = v;
        nmi = v;
    endtask

    // behavioural prediction of one boundary
    task automatic model_pick(input logic [1:0] k, input logic [7:0] t,
                              input logic [15:0] f, input string rq);
        int          src;   // 0 none 1 sw 2 nmi 3 intr 4 skip
        logic [7:0]  ty;
        logic [15:0] s;
        logic [19:0] va;
        exp_t        e;
        src = 0; ty = t;
        if (k == 2'b01)               src = 1;
        else if (k == 2'b10)        begin src = 1; ty = 8'd3; end
        else if (k == 2'b11 && f[11]) begin src = 1; ty = 8'd4; end
        if (src == 0) begin
            if (m_nmi_pend)         begin src = 2; ty = 8'd2; m_nmi_pend = 0; end
            else if (intr && f[9])  begin src = 3; ty = ack_type; end
            else if (k == 2'b11)      src = 4;
        end
        if (src == 0) return;
        if (src == 3) begin
            for (int i = 0; i < 2; i++) begin
                e = blank("R7"); e.inta = 1; q.push_back(e);
            end
        end
        if (src != 4) begin
            s = sp_v;
            for (int i = 0; i < 3; i++) begin
                s = s - 16'd2;
                e = blank("R2"); e.req = 1; e.we = 1; e.addr = ph(ss_v, s);
                e.wd = (i == 0) ? f : (i == 1) ? cs_v : ip_v;
                q.push_back(e);
            end
            va = {10'd0, ty, 2'b00};
            e = blank("R1"); e.req = 1; e.addr = va;         q.push_back(e);
            e = blank("R1"); e.req = 1; e.addr = va + 20'd2; q.push_back(e);
        end
        va = {10'd0, ty, 2'b00};
        e = blank(rq); e.done = 1; e.taken = (src != 4); e.typ = ty;
        e.nip = vw(va); e.ncs = vw(va + 20'd2);
        e.nfl = f & 16'hFCFF; e.sp = sp_v - 16'd6;
        q.push_back(e);
        q.push_back(blank(rq));
    endtask

    task automatic bnd(input logic [1:0] k, input logic [7:0] t, input logic [15:0] f,
                       input string rq);
        boundary = 1; sw_kind = k; sw_type = t; flags = f;
        if (q.size() == 0) model_pick(k, t, f, rq);
        cyc();
        boundary = 0; sw_kind = 2'b00;
    endtask

    bit finished = 0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            nbad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        rst_n = 0; boundary = 0; sw_kind = 0; sw_type = 0; nmi = 0; intr = 0;
        flags = 0; cs_v = 16'h1234; ip_v = 16'h0102; ss_v = 16'h2000; sp_v = 16'h0100;
        ack_type = 8'h40;
        repeat (3) @(negedge clk);
        rst_n = 1;
        idle_tag = "R12";
        run(3);

        // R1 R2 R3 R11: numbered INT with IF, TF, OF set
        bnd(2'b01, 8'h21, 16'h0B02, "R11");
        run(10);
        // R8: breakpoint and taken overflow trap
        cs_v = 16'hBEEF; ip_v = 16'h0F00;
        bnd(2'b10, 8'h77, 16'h0200, "R8");
        run(10);
        bnd(2'b11, 8'h00, 16'h0800, "R8");
        run(10);
        // R9: overflow trap with OF clear, nothing pending
        bnd(2'b11, 8'h00, 16'h0200, "R9");
        run(4);
        // R4: edge served with IF clear; held level does not re-request
        set_nmi(1); cyc();
        bnd(2'b00, 8'h00, 16'h0000, "R4");
        run(10);
        idle_tag = "R4";
        bnd(2'b00, 8'h00, 16'h0000, "R4");
        run(3);
        set_nmi(0); cyc();
        // R6: maskable masked, then R7 acknowledged
        intr = 1; idle_tag = "R6";
        bnd(2'b00, 8'h00, 16'h0000, "R6");
        run(3);
        bnd(2'b00, 8'h00, 16'h0200, "R7");
        run(12);
        intr = 0;
        // R5: all three at one boundary, NMI edge in the same cycle
        intr = 1; ack_type = 8'h55; set_nmi(1);
        bnd(2'b01, 8'h80, 16'h0200, "R5");
        run(10);
        bnd(2'b00, 8'h00, 16'h0200, "R5");
        run(10);
        bnd(2'b00, 8'h00, 16'h0200, "R5");
        run(12);
        intr = 0; set_nmi(0); cyc();
        // R10: edge and stray boundary during an entry
        bnd(2'b01, 8'h30, 16'h0200, "R10");
        cyc();
        set_nmi(1);
        bnd(2'b10, 8'h00, 16'h0200, "R10");
        intr = 1; cyc(); intr = 0;   // R6: pulse gone by next boundary
        run(8);
        bnd(2'b00, 8'h00, 16'h0200, "R10");
        run(10);
        idle_tag = "R6";
        bnd(2'b00, 8'h00, 16'h0200, "R6");
        run(3);
        set_nmi(0); cyc();
        // R9: untaken trap falls through to pending NMI
        set_nmi(1);
        bnd(2'b11, 8'h00, 16'h0000, "R9");
        run(10);
        set_nmi(0); cyc();
        // R2: stack offset and physical address wrap
        ss_v = 16'hFFFF; sp_v = 16'h0002;
        bnd(2'b01, 8'hFF, 16'h0302, "R2");
        run(10);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule